// File: doc/BRIEF.md
# Sequential Restoring Integer Divider

This block divides one N-bit integer by another over several clock cycles and returns both the quotient and the remainder. One input flag selects signed or unsigned operation for each division. The block keeps a single shifting register of 2N+1 bits. The dividend enters the low half. On each step the divisor is trial-subtracted from the high half only. When the trial result is negative, the high half keeps its old value, which restores it. Each new quotient bit shifts in at the low end. After the last step, the high half holds the remainder scaled up by one place, and the block shifts it right by one to correct this.

In signed mode the block divides the magnitudes and then fixes the signs. The quotient is negated when the two operand signs differ. The remainder takes the sign of the dividend. Dividing by zero does not raise an error and returns a fixed result. Dividing the most negative value by minus one also returns a fixed result.

A host pulses `start` while the block is idle. It then waits for the one-cycle `done` pulse and reads `quotient` and `remainder`. These outputs stay unchanged until the next division completes.

Top module: `seq_divider`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy`, `done`, `quotient` and `remainder` are all zero.
- R2: A `start` sampled while `busy` is low is accepted: `busy` is high from the next cycle. `done` rises exactly WIDTH+1 clock edges after the edge that sampled `start`. `done` is high for one cycle, and `busy` is low in that cycle.
- R3: With `is_signed` = 0 and a nonzero divisor, `quotient` = floor(dividend / divisor) and `remainder` = dividend − quotient × divisor, both unsigned.
- R4: With `is_signed` = 1 and a nonzero divisor, the operands are two's complement. The quotient truncates toward zero, so it is negated when the operand signs differ. A nonzero remainder has the sign of the dividend, and its magnitude is below that of the divisor.
- R5: A zero divisor gives `quotient` = all ones and `remainder` = the dividend bit pattern, in both modes.
- R6: With `is_signed` = 1, the most negative value (only the top bit set) divided by all ones (−1) gives `quotient` = the most negative value and `remainder` = 0.
- R7: A `start` pulse while `busy` is high is ignored: it changes neither the result nor the timing of the division in progress.
- R8: `quotient` and `remainder` change only in the cycle where `done` rises. They hold their values while `done` is low, whatever the inputs do.
- R9: With `is_signed` = 0, operands with the top bit set are read as large unsigned values, not as negative numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a division when idle |
| is_signed | input | 1 | 1 = two's complement operands, 0 = unsigned |
| dividend | input | WIDTH | Numerator |
| divisor | input | WIDTH | Denominator |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: results are valid |
| quotient | output | WIDTH | Quotient of the last completed division |
| remainder | output | WIDTH | Remainder of the last completed division |

## Verification
The bench targets the cases that expose each kind of flaw:
- **Mixed-sign signed operands.** A design that fixed signs wrongly would return a floored quotient or a remainder whose sign matches the divisor.
- **A zero divisor with a negative signed dividend.** A design without an explicit override would negate its all-ones quotient into one.
- **The most negative value divided by minus one.** A careless magnitude or negation path would return a zero or positive quotient here.
- **Unsigned operands with the top bit set.** A design that skipped the final one-place right shift would report double the remainder.

The bench also measures the exact cycle count to `done`. It sends a second `start` in the middle of a division, which would corrupt the result if it were not ignored. Finally, it checks that the outputs hold steady between completions.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_t;
endpackage

// File: rtl/div_operand_prep.sv
// Converts raw operands into magnitudes plus the sign decisions for the result.
module div_operand_prep #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_d,
  input  logic             signed_mode,
  output logic [WIDTH-1:0] mag_a,
  output logic [WIDTH-1:0] mag_d,
  output logic             flip_quo,
  output logic             flip_rem,
  output logic             zero_div
);
  logic a_neg, d_neg;

  always_comb begin
    a_neg    = signed_mode & op_a[WIDTH-1];
    d_neg    = signed_mode & op_d[WIDTH-1];
    // negating the most negative value yields 2^(WIDTH-1), correct as unsigned
    mag_a    = a_neg ? (~op_a + 1'b1) : op_a;
    mag_d    = d_neg ? (~op_d + 1'b1) : op_d;
    flip_quo = a_neg ^ d_neg;
    flip_rem = a_neg;
    zero_div = (op_d == '0);
  end
endmodule

// File: rtl/div_restore_core.sv
// Shifting 2*WIDTH+1 bit register: high half is the partial remainder,
// low half starts as the dividend and fills with quotient bits.
module div_restore_core #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             step,
  input  logic [WIDTH-1:0] mag_a,
  input  logic [WIDTH-1:0] mag_d,
  output logic [WIDTH-1:0] raw_quo,
  output logic [WIDTH-1:0] raw_rem
);
  localparam int RW = 2 * WIDTH + 1;

  logic [RW-1:0]    acc;
  logic [WIDTH-1:0] dvs;
  logic [WIDTH:0]   hi;
  logic [WIDTH+1:0] trial;
  logic             trial_neg;
  logic [WIDTH:0]   hi_next;

  always_comb begin
    hi        = acc[RW-1:WIDTH];
    trial     = {1'b0, hi} - {2'b00, dvs};
    trial_neg = trial[WIDTH+1];
    // restore: keep the old high half when the subtraction went negative
    hi_next   = trial_neg ? hi : trial[WIDTH:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      dvs <= '0;
    end else if (load) begin
      acc <= {{WIDTH{1'b0}}, mag_a, 1'b0};
      dvs <= mag_d;
    end else if (step) begin
      acc <= {hi_next[WIDTH-1:0], acc[WIDTH-1:0], ~trial_neg};
    end
  end

  // final one-place right shift of the high half undoes the extra shift
  assign raw_rem = acc[RW-1:WIDTH+1];
  assign raw_quo = acc[WIDTH-1:0];

  // partial remainder stays below twice the divisor before every step
  assert_partial_bound_R3: assert property (@(posedge clk) disable iff (rst)
    (step && dvs != '0) |-> (hi < {dvs, 1'b0}));
endmodule

// File: rtl/div_result_fix.sv
// Applies sign corrections and the divide-by-zero override.
module div_result_fix #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] raw_quo,
  input  logic [WIDTH-1:0] raw_rem,
  input  logic [WIDTH-1:0] orig_a,
  input  logic             flip_quo,
  input  logic             flip_rem,
  input  logic             zero_div,
  output logic [WIDTH-1:0] fin_quo,
  output logic [WIDTH-1:0] fin_rem
);
  always_comb begin
    if (zero_div) begin
      fin_quo = '1;
      fin_rem = orig_a;
    end else begin
      fin_quo = flip_quo ? (~raw_quo + 1'b1) : raw_quo;
      fin_rem = flip_rem ? (~raw_rem + 1'b1) : raw_rem;
    end
  end
endmodule

// File: rtl/seq_divider.sv
module seq_divider
  import div_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             is_signed,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int CW = $clog2(WIDTH) + 1;

  div_state_t       state;
  logic [CW-1:0]    step_cnt;
  logic [WIDTH-1:0] a_q;
  logic             sgn_q, flip_quo_q, flip_rem_q, zero_div_q;

  logic [WIDTH-1:0] mag_a, mag_d, raw_quo, raw_rem, fin_quo, fin_rem;
  logic             flip_quo, flip_rem, zero_div;
  logic             accept, step;

  assign accept = (state == ST_IDLE) && start;
  assign step   = (state == ST_RUN);

  div_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .op_a(dividend), .op_d(divisor), .signed_mode(is_signed),
    .mag_a(mag_a), .mag_d(mag_d),
    .flip_quo(flip_quo), .flip_rem(flip_rem), .zero_div(zero_div)
  );

  div_restore_core #(.WIDTH(WIDTH)) u_core (
    .clk(clk), .rst(rst), .load(accept), .step(step),
    .mag_a(mag_a), .mag_d(mag_d),
    .raw_quo(raw_quo), .raw_rem(raw_rem)
  );

  div_result_fix #(.WIDTH(WIDTH)) u_fix (
    .raw_quo(raw_quo), .raw_rem(raw_rem), .orig_a(a_q),
    .flip_quo(flip_quo_q), .flip_rem(flip_rem_q), .zero_div(zero_div_q),
    .fin_quo(fin_quo), .fin_rem(fin_rem)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      step_cnt   <= '0;
      a_q        <= '0;
      sgn_q      <= 1'b0;
      flip_quo_q <= 1'b0;
      flip_rem_q <= 1'b0;
      zero_div_q <= 1'b0;
      busy       <= 1'b0;
      done       <= 1'b0;
      quotient   <= '0;
      remainder  <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            state      <= ST_RUN;
            step_cnt   <= '0;
            a_q        <= dividend;
            sgn_q      <= is_signed;
            flip_quo_q <= flip_quo;
            flip_rem_q <= flip_rem;
            zero_div_q <= zero_div;
            busy       <= 1'b1;
          end
        end
        ST_RUN: begin
          if (step_cnt == CW'(WIDTH - 1)) state <= ST_FIX;
          else                            step_cnt <= step_cnt + 1'b1;
        end
        ST_FIX: begin
          quotient  <= fin_quo;
          remainder <= fin_rem;
          done      <= 1'b1;
          busy      <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_busy_after_start_R2: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_not_busy_R2: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  assert_rem_sign_R4: assert property (@(posedge clk) disable iff (rst)
    (done && sgn_q && !zero_div_q && remainder != '0) |-> (remainder[WIDTH-1] == a_q[WIDTH-1]));
  assert_zero_div_R5: assert property (@(posedge clk) disable iff (rst)
    (done && zero_div_q) |-> (quotient == '1 && remainder == a_q));
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (rst)
    busy |=> $stable(a_q));
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (state != ST_FIX) |=> ($stable(quotient) && $stable(remainder)));
endmodule

// File: tb/test_seq_divider.sv
module test_seq_divider;
  localparam int W = 16;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         is_signed = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done;
  logic [W-1:0] quotient, remainder;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  seq_divider #(.WIDTH(W)) i_seq_divider (
    .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic expect_result(input logic [W-1:0] a, input logic [W-1:0] d,
                               input logic sgn, output logic [W-1:0] eq,
                               output logic [W-1:0] er);
    int as, ds, qi, ri;
    if (d == '0) begin
      eq = '1; er = a;
    end else if (sgn) begin
      as = int'($signed(a)); ds = int'($signed(d));
      qi = as / ds; ri = as % ds;
      eq = qi[W-1:0]; er = ri[W-1:0];
    end else begin
      eq = a / d; er = a % d;
    end
  endtask

  // one division; poke=1 sends a second start mid-run (R7)
  task automatic run_case(input logic [W-1:0] a, input logic [W-1:0] d,
                          input logic sgn, input string req, input bit poke);
    logic [W-1:0] eq, er;
    int cnt;
    expect_result(a, d, sgn, eq, er);
    @(negedge clk);
    dividend = a; divisor = d; is_signed = sgn; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R2", "busy after start", 32'(busy), 32'd1);
    cnt = 0;
    while (done !== 1'b1 && cnt < 200) begin
      if (poke && cnt == 3) begin
        dividend = ~a; divisor = d + 16'd3; is_signed = ~sgn; start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      cnt++;
    end
    check(cnt == W + 1, "R2", "latency", 32'(cnt), 32'(W + 1));
    check(busy === 1'b0, "R2", "busy with done", 32'(busy), 32'd0);
    check(quotient === eq, req, "quotient", 32'(quotient), 32'(eq));
    check(remainder === er, req, "remainder", 32'(remainder), 32'(er));
  endtask

  // outputs must hold while done is low (R8)
  task automatic hold_case();
    logic [W-1:0] q0, r0;
    q0 = quotient; r0 = remainder;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      dividend = dividend + 16'd17; divisor = divisor ^ 16'h00F0; is_signed = ~is_signed;
      check(done === 1'b0, "R8", "done low", 32'(done), 32'd0);
    end
    check(quotient === q0, "R8", "quotient held", 32'(quotient), 32'(q0));
    check(remainder === r0, "R8", "remainder held", 32'(remainder), 32'(r0));
  endtask

  task automatic reset_case();
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R1", "flags in reset", {30'd0, busy, done}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check(quotient === '0, "R1", "quotient after reset", 32'(quotient), 32'd0);
    check(remainder === '0, "R1", "remainder after reset", 32'(remainder), 32'd0);
    check(busy === 1'b0 && done === 1'b0, "R1", "flags after reset", {30'd0, busy, done}, 32'd0);
  endtask

  initial begin
    reset_case();
    // R3 unsigned
    run_case(16'd100, 16'd7, 1'b0, "R3", 0);
    run_case(16'd5, 16'd9, 1'b0, "R3", 0);
    run_case(16'd0, 16'd3, 1'b0, "R3", 0);
    run_case(16'hFFFF, 16'd1, 1'b0, "R3", 0);
    run_case(16'hFFFF, 16'hFFFF, 1'b0, "R3", 0);
    // R9 top bit set in unsigned mode
    run_case(16'h8001, 16'd2, 1'b0, "R9", 0);
    run_case(16'hF000, 16'h8001, 1'b0, "R9", 0);
    run_case(16'h8000, 16'hFFFF, 1'b0, "R9", 0);
    // R4 signed, all sign combinations
    run_case(16'hFF9C, 16'd7, 1'b1, "R4", 0);
    run_case(16'd100, 16'hFFF9, 1'b1, "R4", 0);
    run_case(16'hFF9C, 16'hFFF9, 1'b1, "R4", 0);
    run_case(16'hFFFF, 16'd2, 1'b1, "R4", 0);
    run_case(16'h7FFF, 16'h8000, 1'b1, "R4", 0);
    // R5 divide by zero
    run_case(16'd1234, 16'd0, 1'b0, "R5", 0);
    run_case(16'hFFFB, 16'd0, 1'b1, "R5", 0);
    // R6 signed overflow
    run_case(16'h8000, 16'hFFFF, 1'b1, "R6", 0);
    // R7 start while busy ignored
    run_case(16'd5000, 16'd33, 1'b0, "R7", 1);
    run_case(16'hEC78, 16'd13, 1'b1, "R7", 1);
    // R8 hold
    hold_case();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule